// File: doc/BRIEF.md
# External bus cycle-rate and strobe controller

This block sits between a chip's bus request logic and the pins of an external memory bus. A byte-wide control register selects whether the external bus runs at the internal clock rate or at half of it, and whether the I/O read and write strobes take part in static-memory style cycles. Static RAM, external ROM and external I/O cycles follow the rate setting. Page-mode ROM and EDO DRAM cycles always run at full rate and never drive the I/O strobes, because their own controllers handle those cycles.

A request is offered on a valid/ready pair. It carries an access type, a read/write flag and a flag that marks a flyby DMA transfer. `req_ready` is high only while no bus cycle is in progress. A requester holds `req_valid` and its payload stable until the edge where both are high. The payload is sampled only on that edge. The block then runs a cycle of `BUS_PHASES` bus phases, and `bus_phase_en` marks each phase. During half-rate cycles a gated bus clock is emitted. A separate clock-out pin can pass the full-rate internal clock through whatever the bus rate.

Register writes are accepted at any time and read back at once. The setting that the bus actually uses is copied from the written value only while the bus is idle, so a write that lands during a cycle changes nothing until that cycle has finished.

Top module: `extbus_rate_ctrl`

## Requirements
- R1: The control register resets to 0x00, is written as a whole byte, and keeps only bit 7 (rate select) and bit 3 (strobe enable); every other bit reads back as 0.
- R2: With bit 7 clear, every access lasts `BUS_PHASES` clocks and `bus_phase_en` is high in each of them.
- R3: With bit 7 set, a static RAM (type 0), external ROM (type 1) or external I/O (type 2) access lasts 2×`BUS_PHASES` clocks, and `bus_phase_en` is high in the second, fourth, … clock of the access and low in the others.
- R4: Page ROM (type 3), EDO DRAM (type 4) and the unused codes 5 to 7 always run at full rate, as in R2, whatever bit 7 holds.
- R5: `bus_clk` is high in the first clock of a half-rate access and then alternates every clock. It is low while idle, in full-rate accesses and in types 3 to 7.
- R6: In types 0 to 2, the strobes are driven when bit 3 is set or the flyby flag is set. When both are clear, the strobes stay high.
- R7: In types 3 to 7, `iord_n` and `iowr_n` stay high whatever bit 3 and the flyby flag hold.
- R8: Both strobes are active low. `iord_n` is driven only for reads and `iowr_n` only for writes. A driven strobe is low in bus phases 0 to `BUS_PHASES`-2 and high in the final phase and while idle.
- R9: A register write that lands during an access does not change that access. The next access uses the new value.
- R10: `clk_out` follows the internal clock while `clk_out_sel` is high, including during half-rate accesses, and is low otherwise.
- R11: `req_ready` is high exactly when no access is in progress. A request is accepted on the edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next clock until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register byte write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_type | input | 3 | Access type: 0 SRAM, 1 ext ROM, 2 ext I/O, 3 page ROM, 4 EDO DRAM |
| req_write | input | 1 | 1 for write, 0 for read |
| req_flyby | input | 1 | Access is part of a flyby DMA transfer |
| clk_out_sel | input | 1 | Select full-rate clock on clk_out |
| bus_phase_en | output | 1 | One-clock enable marking each bus phase |
| bus_clk | output | 1 | Gated bus clock, half-rate accesses only |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| clk_out | output | 1 | Pass-through internal clock |

## Verification
The bench targets the interaction of the rate bit with the access type. A design that halved page ROM or EDO DRAM cycles, or that let the gated clock run there, would show extra clocks or a toggling `bus_clk`. Flyby transfers with the strobe enable clear should still drive strobes on static types and never on page or DRAM types. A design that let the override leak across types, or that ignored it, would get the strobe level wrong in the first phase. A write issued in the middle of a cycle checks that the running access keeps its length and strobe pattern, and that the following access picks up the new setting. The final-phase strobe release and a gated clock that starts high catch off-by-one errors in the phase counter and the divider.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic [2:0] {
    ACC_SRAM = 3'd0,
    ACC_XROM = 3'd1,
    ACC_XIO  = 3'd2,
    ACC_PROM = 3'd3,
    ACC_EDO  = 3'd4
  } acc_t;

  localparam int RATE_BIT = 7;
  localparam int STB_BIT  = 3;
  localparam logic [7:0] CFG_MASK = 8'((1 << RATE_BIT) | (1 << STB_BIT));

  typedef struct packed {
    logic half_rate;
    logic stb_en;
  } cfg_t;

  function automatic logic is_static(input logic [2:0] t);
    return (t == ACC_SRAM) || (t == ACC_XROM) || (t == ACC_XIO);
  endfunction
endpackage

// File: rtl/ebr_cfg_reg.sv
module ebr_cfg_reg
  import ebr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       hold,
  output logic [7:0] rdata,
  output cfg_t       active
);
  logic [7:0] shadow_q;
  logic [7:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (we) shadow_q <= wdata & CFG_MASK;
      if (!hold) live_q <= shadow_q;
    end
  end

  assign rdata            = shadow_q;
  assign active.half_rate = live_q[RATE_BIT];
  assign active.stb_en    = live_q[STB_BIT];
endmodule

// File: rtl/ebr_phase_gen.sv
module ebr_phase_gen #(
  parameter int BUS_PHASES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half,
  output logic busy,
  output logic phase_en,
  output logic in_last,
  output logic gclk
);
  localparam int PH_W = (BUS_PHASES > 1) ? $clog2(BUS_PHASES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(BUS_PHASES - 1);

  logic            busy_q;
  logic            div_q;
  logic [PH_W-1:0] ph_q;

  assign phase_en = busy_q & (~half | div_q);
  assign in_last  = busy_q & (ph_q == LAST);
  assign gclk     = busy_q & half & ~div_q;
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      ph_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      div_q  <= 1'b0;
      ph_q   <= '0;
    end else if (busy_q) begin
      div_q <= half ? ~div_q : 1'b0;
      if (phase_en) begin
        if (ph_q == LAST) busy_q <= 1'b0;
        else              ph_q   <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebr_strobe_gen.sv
module ebr_strobe_gen (
  input  logic busy,
  input  logic in_last,
  input  logic static_acc,
  input  logic stb_en,
  input  logic flyby,
  input  logic write,
  output logic iord_n,
  output logic iowr_n
);
  logic drive;

  always_comb begin
    drive  = busy & ~in_last & static_acc & (stb_en | flyby);
    iord_n = ~(drive & ~write);
    iowr_n = ~(drive & write);
  end
endmodule

// File: rtl/extbus_rate_ctrl.sv
module extbus_rate_ctrl
  import ebr_pkg::*;
#(
  parameter int BUS_PHASES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_type,
  input  logic       req_write,
  input  logic       req_flyby,
  input  logic       clk_out_sel,
  output logic       bus_phase_en,
  output logic       bus_clk,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       clk_out
);
  cfg_t       cfg;
  logic       busy;
  logic       in_last;
  logic       start;
  logic [2:0] type_q;
  logic       write_q;
  logic       flyby_q;
  logic       static_acc;
  logic       half;

  assign req_ready  = ~busy;
  assign start      = req_valid & ~busy;
  assign static_acc = is_static(type_q);
  assign half       = cfg.half_rate & static_acc;
  assign clk_out    = clk_out_sel & clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= ACC_PROM;
      write_q <= 1'b0;
      flyby_q <= 1'b0;
    end else if (start) begin
      type_q  <= req_type;
      write_q <= req_write;
      flyby_q <= req_flyby;
    end
  end

  ebr_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .hold   (busy),
    .rdata  (cfg_rdata),
    .active (cfg)
  );

  ebr_phase_gen #(.BUS_PHASES(BUS_PHASES)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .half     (half),
    .busy     (busy),
    .phase_en (bus_phase_en),
    .in_last  (in_last),
    .gclk     (bus_clk)
  );

  ebr_strobe_gen u_stb (
    .busy       (busy),
    .in_last    (in_last),
    .static_acc (static_acc),
    .stb_en     (cfg.stb_en),
    .flyby      (flyby_q),
    .write      (write_q),
    .iord_n     (iord_n),
    .iowr_n     (iowr_n)
  );
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic       bus_phase_en,
  input logic       bus_clk,
  input logic       iord_n,
  input logic       iowr_n
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'h77) == 8'h00);                                   // R1
  AST_HALF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |=> bus_phase_en && !bus_clk);                            // R3
  AST_GCLK_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> !bus_phase_en);                                       // R5
  AST_GCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_clk && !bus_phase_en);                         // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~iord_n, ~iowr_n}) <= 1);                             // R8
  AST_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> iord_n && iowr_n);                                  // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);                           // R11
endmodule

bind extbus_rate_ctrl ebr_checker u_ebr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdata    (cfg_rdata),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .bus_phase_en (bus_phase_en),
  .bus_clk      (bus_clk),
  .iord_n       (iord_n),
  .iowr_n       (iowr_n)
);

// File: tb/extbus_rate_ctrl_tb.sv
`timescale 1ns/1ps
module extbus_rate_ctrl_tb_top;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_type = '0;
  logic req_write = 1'b0;
  logic req_flyby = 1'b0;
  logic clk_out_sel = 1'b0;
  logic bus_phase_en, bus_clk, iord_n, iowr_n, clk_out;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] shadow = '0;

  always #10 clk = ~clk;

  extbus_rate_ctrl #(.BUS_PHASES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_write(req_write), .req_flyby(req_flyby),
    .clk_out_sel(clk_out_sel), .bus_phase_en(bus_phase_en), .bus_clk(bus_clk),
    .iord_n(iord_n), .iowr_n(iowr_n), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic bit f_static(input logic [2:0] t);
    return t <= 3'd2;
  endfunction

  function automatic bit f_half(input logic [7:0] c, input logic [2:0] t);
    return c[7] && f_static(t);
  endfunction

  function automatic bit f_drive(input logic [7:0] c, input logic [2:0] t, input bit fl);
    return f_static(t) && (c[3] || fl);
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = v & 8'h88;
    check(cfg_rdata == shadow, "R1 readback", cfg_rdata, shadow);
  endtask

  // Called just after a negedge with the block idle.
  task automatic run_access(input logic [2:0] t, input bit wr, input bit fl,
                            input bit mid_wr, input logic [7:0] mid_val);
    logic [7:0] used = shadow;
    bit h = f_half(used, t);
    bit d = f_drive(used, t, fl);
    int n = h ? 2 * NP : NP;
    check(req_ready == 1'b1, "R11 ready idle", req_ready, 1);
    req_valid = 1'b1; req_type = t; req_write = wr; req_flyby = fl;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      int ph = h ? i / 2 : i;
      bit e_en = h ? (i % 2 == 1) : 1'b1;
      bit e_gc = h && (i % 2 == 0);
      bit low = d && (ph < NP - 1);
      check(req_ready == 1'b0, "R11 busy", req_ready, 0);
      check(bus_phase_en == e_en, h ? "R3 phase enable" : (f_static(t) ? "R2 phase enable" : "R4 phase enable"),
            bus_phase_en, e_en);
      check(bus_clk == e_gc, "R5 bus clock", bus_clk, e_gc);
      check(iord_n == !(low && !wr), f_static(t) ? "R6 R8 read strobe" : "R7 read strobe",
            iord_n, !(low && !wr));
      check(iowr_n == !(low && wr), f_static(t) ? "R6 R8 write strobe" : "R7 write strobe",
            iowr_n, !(low && wr));
      if (mid_wr && i == 0) begin
        cfg_we = 1'b1; cfg_wdata = mid_val;
      end
      @(negedge clk);
      if (mid_wr && i == 0) begin
        cfg_we = 1'b0;
        shadow = mid_val & 8'h88;
        check(cfg_rdata == shadow, "R9 R1 readback during access", cfg_rdata, shadow);
      end
    end
    check(req_ready == 1'b1, "R11 ready after access", req_ready, 1);
    check(bus_clk == 1'b0 && bus_phase_en == 1'b0, "R5 idle after access",
          {bus_clk, bus_phase_en}, 0);
    check(iord_n && iowr_n, "R8 strobes idle", {iord_n, iowr_n}, 2'b11);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4021);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
    check(req_ready && !bus_clk && !bus_phase_en && iord_n && iowr_n, "R11 reset idle",
          {req_ready, bus_clk, bus_phase_en, iord_n, iowr_n}, 5'b10011);

    write_cfg(8'hFF);                                   // R1 reserved bits drop
    write_cfg(8'h00);
    run_access(3'd0, 1'b0, 1'b0, 1'b0, 8'h0);           // R2 full rate, no strobe
    run_access(3'd2, 1'b1, 1'b1, 1'b0, 8'h0);           // R6 flyby override
    write_cfg(8'h08);
    run_access(3'd1, 1'b0, 1'b0, 1'b0, 8'h0);           // R8 read strobe
    run_access(3'd4, 1'b1, 1'b1, 1'b0, 8'h0);           // R7 EDO no strobe
    write_cfg(8'h80);
    run_access(3'd0, 1'b1, 1'b1, 1'b0, 8'h0);           // R3 half rate flyby write
    run_access(3'd3, 1'b0, 1'b1, 1'b0, 8'h0);           // R4 page ROM full rate
    run_access(3'd2, 1'b0, 1'b0, 1'b0, 8'h0);           // R6 suppressed
    run_access(3'd0, 1'b0, 1'b0, 1'b1, 8'h08);          // R9 mid-cycle write
    run_access(3'd0, 1'b0, 1'b0, 1'b0, 8'h0);           // R9 new value used

    clk_out_sel = 1'b1;                                 // R10
    write_cfg(8'h80);
    req_valid = 1'b1; req_type = 3'd0;
    @(posedge clk); #5;
    req_valid = 1'b0;
    check(clk_out == 1'b1, "R10 clock out high", clk_out, 1);
    @(negedge clk); #1;
    check(clk_out == 1'b0, "R10 clock out low", clk_out, 0);
    @(posedge clk); #5;
    check(clk_out == 1'b1, "R10 clock out during half rate", clk_out, 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    clk_out_sel = 1'b0;
    @(posedge clk); #5;
    check(clk_out == 1'b0, "R10 clock out deselected", clk_out, 0);
    @(negedge clk);

    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) write_cfg(8'($urandom()));
      run_access(3'($urandom_range(0, 7)), 1'($urandom()), 1'($urandom()),
                 ($urandom_range(0, 5) == 0), 8'($urandom()));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule